// File: doc/BRIEF.md
# Gated Timer Pair

Two identical up-counting timers run from one clock. Each has a programmable prescaler, a reload limit and a compare value, and each makes a compare waveform that is high while its counter is below the compare value. One timer, the leader, can put that waveform on its trigger output. The other, the follower, can take the leader's trigger as a gate: its counter then advances on its own prescaled ticks only while the sampled trigger is high, and holds while it is low. Every change of the sampled gate sets a trigger flag that software clears by writing zero to it.

Software programs both timers through one write port. A timer-select bit picks the timer and a 3-bit address picks the register. The usual order is to set up the follower, load its counter, enable it, and enable the leader last. The enable bit alone does not start a gated follower. A software update event clears a timer's counter and prescaler phase. Without that event, a timer resumes from whatever counter and prescaler state it held.

Top module: `gated_timer_pair`

## Requirements
- R1: After reset both counters read 0, the leader compare output is 0 and the follower flag is 0.
- R2: With the enable bit (control bit 0) set, a counter advances by one every P+1 clock cycles, where P is the prescale register (address 1). The first increment comes P+1 clock edges after the edge that registers the enable.
- R3: A counter that equals its reload register (address 3) goes to 0 on its next counting tick.
- R4: The leader compare output is high while the leader is enabled and its counter is below its compare register (address 2). It is low otherwise, and always low while the leader is disabled.
- R5: A trigger output carries the compare output only when the output-select field (control bits 3:1) is 100. Any other value drives it to 0.
- R6: A trigger-source field (control bits 6:4) of 000 feeds a timer with the other timer's trigger output. Any other value feeds it 0.
- R7: A slave-mode field (control bits 9:7) of 101 selects gated counting. The trigger is registered once. A counting tick advances the counter only while that registered trigger is 1, and the counter holds otherwise. Setting the enable bit alone does not start a gated timer. Other slave-mode values count on every tick.
- R8: Writing 1 to bit 0 of the event register (address 5) clears that timer's counter and prescaler phase on the next clock. It acts only in the cycle of the write.
- R9: A write to the counter register (address 4) loads that value on the next clock.
- R10: In gated mode, every change of the registered trigger sets the flag. A write to the flag register (address 6) with bit 0 equal to 0 clears it, and a write with bit 0 equal to 1 leaves it unchanged.
- R11: Clearing the enable bit freezes the counter and the prescaler phase. Setting it again resumes from the frozen state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both timers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_tmr | input | 1 | Timer select: 0 leader, 1 follower |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| mst_cnt | output | 16 | Leader counter value |
| slv_cnt | output | 16 | Follower counter value |
| mst_ref | output | 1 | Leader compare waveform |
| slv_tflag | output | 1 | Follower trigger flag |

## Verification
The embedded properties assume one register write per cycle. They also assume that a counter load and an update event are never issued together, so the hold and load checks see a single cause. The bench drives each write for one cycle through a task that never overlaps them. It lowers the prescale value only while the timer is stopped and cleared. Gate timing is checked against a hand-derived schedule that counts the extra sampling register on the trigger path.

// File: rtl/gtp_pkg.sv
package gtp_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_PSC  = 3'd1,
    A_CMP  = 3'd2,
    A_RLD  = 3'd3,
    A_CNT  = 3'd4,
    A_EVT  = 3'd5,
    A_FLAG = 3'd6,
    A_RSVD = 3'd7
  } reg_addr_e;

  localparam logic [2:0] MOS_CMPREF  = 3'b100;
  localparam logic [2:0] TSEL_PEER   = 3'b000;
  localparam logic [2:0] SMODE_GATED = 3'b101;

  typedef struct packed {
    logic [2:0] smode;
    logic [2:0] tsel;
    logic [2:0] mos;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/gtp_rst_sync.sv
module gtp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/gtp_prescaler.sv
module gtp_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] pcnt_q, pcnt_d;

  assign tick = run && (pcnt_q >= psc);

  always_comb begin
    pcnt_d = pcnt_q;
    if (clr)       pcnt_d = '0;
    else if (tick) pcnt_d = '0;
    else if (run)  pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  AST_PSC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pcnt_q)); // R11
endmodule

// File: rtl/gtp_counter.sv
module gtp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             step,
  input  logic [CNT_W-1:0] rld,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (ld)   cnt_d = ld_val;
    else if (step) cnt_d = (cnt_q == rld) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !ld && cnt_q == rld) |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/gtp_timer.sv
module gtp_timer
  import gtp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             trig_in,
  output logic [CNT_W-1:0] cnt,
  output logic             cmp_ref,
  output logic             trgo,
  output logic             tflag
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] psc_q, psc_d, cmp_q, cmp_d, rld_q, rld_d;
  logic             flag_q, flag_d;
  logic             trig_s_q;
  logic             sel_trig, gated, tick, step, ug_wr, ld_wr, flag_clr;
  reg_addr_e        addr;

  assign addr     = reg_addr_e'(wr_addr);
  assign ug_wr    = wr_hit && (addr == A_EVT) && wr_data[0];
  assign ld_wr    = wr_hit && (addr == A_CNT);
  assign flag_clr = wr_hit && (addr == A_FLAG) && !wr_data[0];

  assign sel_trig = (ctrl_q.tsel == TSEL_PEER) ? trig_in : 1'b0;
  assign gated    = (ctrl_q.smode == SMODE_GATED);
  assign step     = tick && (!gated || trig_s_q);

  assign cmp_ref  = ctrl_q.en && (cnt < cmp_q);
  assign trgo     = (ctrl_q.mos == MOS_CMPREF) ? cmp_ref : 1'b0;
  assign tflag    = flag_q;

  always_comb begin
    ctrl_d = ctrl_q;
    psc_d  = psc_q;
    cmp_d  = cmp_q;
    rld_d  = rld_q;
    if (wr_hit) begin
      case (addr)
        A_CTRL:  ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
        A_PSC:   psc_d  = wr_data;
        A_CMP:   cmp_d  = wr_data;
        A_RLD:   rld_d  = wr_data;
        default: ;
      endcase
    end
    flag_d = flag_q;
    if (gated && (sel_trig != trig_s_q)) flag_d = 1'b1;
    else if (flag_clr)                   flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      psc_q    <= '0;
      cmp_q    <= '0;
      rld_q    <= '1;
      flag_q   <= 1'b0;
      trig_s_q <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      psc_q    <= psc_d;
      cmp_q    <= cmp_d;
      rld_q    <= rld_d;
      flag_q   <= flag_d;
      trig_s_q <= sel_trig;
    end
  end

  gtp_prescaler #(.PSC_W(CNT_W)) u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ctrl_q.en),
    .clr  (ug_wr),
    .psc  (psc_q),
    .tick (tick)
  );

  gtp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ug_wr),
    .ld    (ld_wr),
    .ld_val(wr_data),
    .step  (step),
    .rld   (rld_q),
    .cnt   (cnt)
  );

  AST_UG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ug_wr |=> (cnt == '0)); // R8
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_wr && !ug_wr) |=> (cnt == $past(wr_data))); // R9
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && !trig_s_q && !ld_wr && !ug_wr) |=> $stable(cnt)); // R7
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && (sel_trig != trig_s_q)) |=> tflag); // R10
endmodule

// File: rtl/gated_timer_pair.sv
module gated_timer_pair #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_tmr,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] mst_cnt,
  output logic [CNT_W-1:0] slv_cnt,
  output logic             mst_ref,
  output logic             slv_tflag
);
  localparam int NUM_TMR = 2;

  logic                rst_sync_n;
  logic [CNT_W-1:0]    cnt_w [NUM_TMR];
  logic [NUM_TMR-1:0]  ref_w, trgo_w, flag_w;
  logic                unused_bits;

  gtp_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    gtp_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .wr_hit (wr_en && (wr_tmr == 1'(g))),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .trig_in(trgo_w[NUM_TMR-1-g]),
      .cnt    (cnt_w[g]),
      .cmp_ref(ref_w[g]),
      .trgo   (trgo_w[g]),
      .tflag  (flag_w[g])
    );
  end

  assign mst_cnt     = cnt_w[0];
  assign slv_cnt     = cnt_w[1];
  assign mst_ref     = ref_w[0];
  assign slv_tflag   = flag_w[1];
  assign unused_bits = ref_w[1] ^ flag_w[0];
endmodule

// File: tb/sim_gated_timer_pair.sv
module sim_gated_timer_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_tmr = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] mst_cnt, slv_cnt;
  logic        mst_ref, slv_tflag;

  int checks = 0;
  int errors = 0;
  int ncyc = 0;
  int base = 0;
  bit done = 1'b0;

  string       tq[$];
  logic [15:0] mcq[$];
  logic [15:0] scq[$];
  logic        rfq[$];
  logic        flq[$];
  event        chk_ev;

  localparam logic [2:0] AD_CTRL = 3'd0, AD_PSC = 3'd1, AD_CMP = 3'd2,
                         AD_RLD = 3'd3, AD_CNT = 3'd4, AD_EVT = 3'd5, AD_FLAG = 3'd6;

  always #5 clk = ~clk;

  gated_timer_pair u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tmr(wr_tmr),
    .wr_addr(wr_addr), .wr_data(wr_data), .mst_cnt(mst_cnt),
    .slv_cnt(slv_cnt), .mst_ref(mst_ref), .slv_tflag(slv_tflag)
  );

  task automatic drain();
    while (tq.size() > 0) begin
      string t;
      logic [15:0] mc, sc;
      logic rf, fl;
      t = tq.pop_front(); mc = mcq.pop_front(); sc = scq.pop_front();
      rf = rfq.pop_front(); fl = flq.pop_front();
      checks++;
      if (mst_cnt !== mc || slv_cnt !== sc || mst_ref !== rf || slv_tflag !== fl) begin
        errors++;
        $display("FAIL %s: mst_cnt=%h slv_cnt=%h mst_ref=%b slv_tflag=%b, expected %h %h %b %b",
                 t, mst_cnt, slv_cnt, mst_ref, slv_tflag, mc, sc, rf, fl);
      end
    end
  endtask

  initial begin : monitor
    forever begin
      @(chk_ev);
      drain();
    end
  end

  task automatic expect_o(string t, logic [15:0] mc, logic [15:0] sc, logic rf, logic fl);
    tq.push_back(t); mcq.push_back(mc); scq.push_back(sc);
    rfq.push_back(rf); flq.push_back(fl);
    -> chk_ev;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
    ncyc += n;
  endtask

  task automatic upto(int k);
    wait_n(k - (ncyc - base));
  endtask

  task automatic wr(logic t, logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_tmr = t; wr_addr = a; wr_data = d;
    @(negedge clk);
    ncyc++;
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    #1;
    drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin : driver
    wait_n(2);
    rst_n = 1'b1;
    wait_n(4);
    expect_o("R1 reset", 16'h0, 16'h0, 1'b0, 1'b0);

    // leader free-running, divide by 3, reload 4
    wr(1'b0, AD_PSC, 16'd2);
    wr(1'b0, AD_RLD, 16'd4);
    wr(1'b0, AD_CTRL, 16'd1);
    base = ncyc;
    upto(2);  expect_o("R2 before first tick", 16'd0, 16'h0, 1'b0, 1'b0);
    upto(3);  expect_o("R2 first tick", 16'd1, 16'h0, 1'b0, 1'b0);
    upto(12); expect_o("R2 fourth tick", 16'd4, 16'h0, 1'b0, 1'b0);
    upto(15); expect_o("R3 wrap", 16'd0, 16'h0, 1'b0, 1'b0);
    wr(1'b0, AD_CTRL, 16'd0);
    upto(20); expect_o("R11 frozen", 16'd0, 16'h0, 1'b0, 1'b0);
    wr(1'b0, AD_CTRL, 16'd1);
    base = ncyc;
    upto(1);  expect_o("R11 resume phase", 16'd0, 16'h0, 1'b0, 1'b0);
    upto(2);  expect_o("R11 resume tick", 16'd1, 16'h0, 1'b0, 1'b0);
    wr(1'b0, AD_CTRL, 16'd0);
    wait_n(3); expect_o("R11 stopped", 16'd1, 16'h0, 1'b0, 1'b0);
    wr(1'b0, AD_CNT, 16'd3);
    expect_o("R9 counter load", 16'd3, 16'h0, 1'b0, 1'b0);
    wr(1'b0, AD_EVT, 16'd1);
    expect_o("R8 update clears", 16'd0, 16'h0, 1'b0, 1'b0);
    wr(1'b0, AD_CTRL, 16'd1);
    base = ncyc;
    upto(2);  expect_o("R8 prescaler cleared", 16'd0, 16'h0, 1'b0, 1'b0);
    upto(3);  expect_o("R8 first tick", 16'd1, 16'h0, 1'b0, 1'b0);
    upto(6);  expect_o("R8 self-clear", 16'd2, 16'h0, 1'b0, 1'b0);

    // gated set-up
    wr(1'b0, AD_CTRL, 16'd0);
    wr(1'b0, AD_EVT, 16'd1);
    wr(1'b0, AD_PSC, 16'd0);
    wr(1'b0, AD_RLD, 16'd9);
    wr(1'b0, AD_CMP, 16'd4);
    wr(1'b1, AD_CNT, 16'h00E7);
    wr(1'b1, AD_CTRL, 16'd641);
    wait_n(4);
    expect_o("R4 ref low while disabled", 16'd0, 16'h00E7, 1'b0, 1'b0);
    expect_o("R7 enable alone holds", 16'd0, 16'h00E7, 1'b0, 1'b0);
    wr(1'b0, AD_CTRL, 16'd9);
    base = ncyc;
    upto(0);  expect_o("R4 ref high below compare", 16'd0, 16'h00E7, 1'b1, 1'b0);
    upto(1);  expect_o("R10 flag on gate open", 16'd1, 16'h00E7, 1'b1, 1'b1);
    upto(2);  expect_o("R7 first gated count", 16'd2, 16'h00E8, 1'b1, 1'b1);
    upto(4);  expect_o("R4 ref low at compare", 16'd4, 16'h00EA, 1'b0, 1'b1);
    upto(5);  expect_o("R7 last gated count", 16'd5, 16'h00EB, 1'b0, 1'b1);
    upto(8);  expect_o("R7 hold gate closed", 16'd8, 16'h00EB, 1'b0, 1'b1);
    wr(1'b1, AD_FLAG, 16'd0);
    expect_o("R10 flag cleared", 16'd9, 16'h00EB, 1'b0, 1'b0);
    upto(10); expect_o("R3 leader wrap", 16'd0, 16'h00EB, 1'b1, 1'b0);
    upto(11); expect_o("R10 flag set again", 16'd1, 16'h00EB, 1'b1, 1'b1);
    upto(12); expect_o("R6 peer trigger counts", 16'd2, 16'h00EC, 1'b1, 1'b1);
    wr(1'b1, AD_FLAG, 16'd1);
    expect_o("R10 write one ignored", 16'd3, 16'h00ED, 1'b1, 1'b1);
    wr(1'b1, AD_CTRL, 16'd657);
    upto(15); expect_o("R6 trailing count", 16'd5, 16'h00EF, 1'b0, 1'b1);
    upto(31); expect_o("R6 other source holds", 16'd1, 16'h00EF, 1'b1, 1'b1);
    upto(34); expect_o("R6 still held", 16'd4, 16'h00EF, 1'b0, 1'b1);
    wr(1'b0, AD_CTRL, 16'd1);
    wr(1'b1, AD_CTRL, 16'd641);
    upto(42); expect_o("R5 ref not routed", 16'd2, 16'h00EF, 1'b1, 1'b1);
    wr(1'b0, AD_CTRL, 16'd9);
    upto(46); expect_o("R5 routed again", 16'd6, 16'h00F0, 1'b0, 1'b1);

    done = 1'b1;
    finish_run();
  end
endmodule